// File: doc/BRIEF.md
# Sequential Add-Shift Unsigned Multiplier

This block multiplies two unsigned operands one multiplier bit at a time. It uses a single accumulator of width 2*WIDTH+1. The upper WIDTH+1 bits hold the running partial sum together with its carry. The lower WIDTH bits start out holding the multiplier and fill with product bits as the value shifts right. A small adder sums the captured multiplicand with the upper accumulator field.

The control is split in two. An add/shift sequencer waits for a start pulse and then looks at the lowest accumulator bit. When that bit is one it adds and then shifts. When it is zero it only shifts. A separate step counter counts the shift commands and flags the final step, which sends the sequencer to a one-cycle completion state.

The caller pulses `start` with both operands valid in the same cycle. The caller then waits for `done` and reads `product`. The product holds its value until the next accepted start.

Top module: `mul_add_shift`

## Requirements
- R1: In the cycle after a synchronous reset, `done` is 0 and `product` is 0.
- R2: When `done` is 1, `product` equals the unsigned product of the multiplicand and multiplier sampled with the accepted start, taken to 2*WIDTH bits.
- R3: `done` goes high exactly WIDTH + (number of one bits in the multiplier) clock cycles after the edge that accepts start. Each one bit costs an add cycle and a shift cycle, and each zero bit costs one shift cycle.
- R4: `done` is high for exactly one cycle per multiplication.
- R5: While idle with `start` low, `product` does not change.
- R6: A `start` pulse during a multiplication, including in its `done` cycle, is ignored. The running result and its latency are unchanged.
- R7: The multiplicand is captured when start is accepted. Changes on `mcand` after that edge do not affect the result.
- R8: A reset in the middle of a multiplication aborts it. No `done` follows, and the next start runs a normal multiplication.
- R9: The corner operands are correct: a zero operand gives 0, and all-ones times all-ones (15*15 = 225 at WIDTH 4) gives the full-width result with the carry captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, accepted only when idle |
| mcand | input | WIDTH | Multiplicand, sampled with start |
| mplier | input | WIDTH | Multiplier, sampled with start |
| product | output | 2*WIDTH | Product, held until the next accepted start |
| done | output | 1 | One-cycle completion flag |

## Verification
A wrong step count or a lost carry bit shows up at the ports in the first `done` cycle. The count error moves `done` off its predicted cycle. The carry error corrupts the high product bits, and all-ones operands expose it. A sequencer that leaves its idle state wrongly shows up within one cycle: either a second `done` pulse appears or the product moves while no start has been accepted. Mid-run starts, operand changes and resets are placed in the busy window, so a design that reacts to them delivers a wrong value or a shifted `done` within WIDTH*2+1 cycles.

// File: rtl/mul_add_shift_pkg.sv
package mul_add_shift_pkg;
  typedef struct packed {
    logic load;
    logic add;
    logic shift;
  } mulStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TEST  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } mulState_t;
endpackage

// File: rtl/mul_step_counter.sv
module mul_step_counter #(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic lastStep
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (rst || clear) stepCnt <= '0;
    else if (step)    stepCnt <= stepCnt + 1'b1;
  end

  // high once WIDTH-1 shifts are behind us, so the coming shift is the final one
  assign lastStep = (stepCnt == CW'(WIDTH - 1));
endmodule

// File: rtl/mul_control.sv
module mul_control
  import mul_add_shift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        mBit,
  output mulStrobes_t strobes,
  output logic        done
);
  mulState_t state, stateNext;
  logic lastStep;

  mul_step_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear    (strobes.load),
    .step     (strobes.shift),
    .lastStep (lastStep)
  );

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.load = 1'b1;
          stateNext    = ST_TEST;
        end
      end
      ST_TEST: begin
        if (mBit) begin
          strobes.add = 1'b1;
          stateNext   = ST_SHIFT;
        end else begin
          strobes.shift = 1'b1;
          stateNext     = lastStep ? ST_DONE : ST_TEST;
        end
      end
      ST_SHIFT: begin
        strobes.shift = 1'b1;
        stateNext     = lastStep ? ST_DONE : ST_TEST;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign done = (state == ST_DONE);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_add_shift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  mulStrobes_t        strobes,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               mBit,
  output logic [2*WIDTH-1:0] product
);
  localparam int AW = 2 * WIDTH + 1;

  logic [AW-1:0]    acc;
  logic [WIDTH-1:0] mcandQ;
  logic [WIDTH:0]   sumHi;

  assign sumHi = {1'b0, acc[AW-2:WIDTH]} + {1'b0, mcandQ};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      mcandQ <= '0;
    end else if (strobes.load) begin
      acc    <= {{(WIDTH+1){1'b0}}, mplier};
      mcandQ <= mcand;
    end else if (strobes.add) begin
      acc[AW-1:WIDTH] <= sumHi;
    end else if (strobes.shift) begin
      acc <= acc >> 1;
    end
  end

  assign mBit    = acc[0];
  assign product = acc[AW-2:0];
endmodule

// File: rtl/mul_add_shift.sv
module mul_add_shift
  import mul_add_shift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);
  mulStrobes_t strobes;
  logic        mBit;

  mul_control #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mBit    (mBit),
    .strobes (strobes),
    .done    (done)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .mcand   (mcand),
    .mplier  (mplier),
    .mBit    (mBit),
    .product (product)
  );
endmodule

// File: rtl/mul_add_shift_chk.sv
module mul_add_shift_chk #(
  parameter int WIDTH = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [WIDTH-1:0]   mcand,
  input logic [WIDTH-1:0]   mplier,
  input logic [2*WIDTH-1:0] product,
  input logic               done
);
  localparam int LW = $clog2(2 * WIDTH + 2) + 1;

  logic               trkBusy;
  logic               prevRst;
  logic [WIDTH-1:0]   capA, capB;
  logic [LW-1:0]      latCnt, latExp;

  always_ff @(posedge clk) begin
    prevRst <= rst;
    if (rst) begin
      trkBusy <= 1'b0;
      latCnt  <= '0;
      latExp  <= '0;
      capA    <= '0;
      capB    <= '0;
    end else if (!trkBusy && start) begin
      trkBusy <= 1'b1;
      latCnt  <= '0;
      latExp  <= LW'(WIDTH) + LW'($countones(mplier));
      capA    <= mcand;
      capB    <= mplier;
    end else if (trkBusy) begin
      latCnt <= latCnt + 1'b1;
      if (done) trkBusy <= 1'b0;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    prevRst |-> (!done && product == '0));

  // R2
  product_value_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (trkBusy && product == (2*WIDTH)'(capA) * (2*WIDTH)'(capB)));

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (latCnt == latExp));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!trkBusy && !start) |=> $stable(product));

  // R8
  no_orphan_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> trkBusy);
endmodule

bind mul_add_shift mul_add_shift_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .mcand   (mcand),
  .mplier  (mplier),
  .product (product),
  .done    (done)
);

// File: tb/tb_mul_add_shift.sv
module tb_mul_add_shift;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic [2*W-1:0] product;
  logic           done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  mul_add_shift #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand),
    .mplier(mplier), .product(product), .done(done)
  );

  // {mcand, mplier}
  localparam logic [7:0] VEC [10] = '{
    8'h00, 8'h35, 8'hD5, 8'h7B, 8'hF1, 8'h1F, 8'hA5, 8'h5A, 8'h08, 8'h80
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Issue one start; optional disturbance at cycle disturbAt:
  // kind 1 = extra start with other operands, 2 = change mcand.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input int kind, input int disturbAt,
                        output int prod, output int lat);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = -1;
    for (int j = 0; j < 40; j++) begin
      if (done) begin
        lat = j;
        break;
      end
      if (j == disturbAt && kind == 1) begin
        start = 1'b1; mcand = ~a; mplier = ~b;
      end else if (j == disturbAt && kind == 2) begin
        mcand = ~a;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    prod = int'(product);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin
    int p, l, expP, expL;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state after reset
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(product == '0, "R1 product after reset", int'(product), 0);

    // R2 / R3 / R4 / R5 / R9 over the vector table
    foreach (VEC[i]) begin
      run_op(VEC[i][7:4], VEC[i][3:0], 0, -1, p, l);
      expP = int'(VEC[i][7:4]) * int'(VEC[i][3:0]);
      expL = W + $countones(VEC[i][3:0]);
      check(p == expP, "R2 R9 product", p, expP);
      check(l == expL, "R3 latency", l, expL);
      @(negedge clk);
      check(done == 1'b0, "R4 done single cycle", int'(done), 0);
      repeat (3) @(negedge clk);
      check(int'(product) == expP, "R5 product held idle", int'(product), expP);
    end

    // R9: all ones times all ones
    run_op(4'hF, 4'hF, 0, -1, p, l);
    check(p == 225, "R9 max operands", p, 225);

    // R6: start during run and during done cycle ignored
    run_op(4'h9, 4'h6, 1, 2, p, l);
    check(p == 54, "R6 mid-run start product", p, 54);
    check(l == W + 2, "R6 mid-run start latency", l, W + 2);
    start = 1'b1; mcand = 4'h3; mplier = 4'h3;
    @(negedge clk);
    start = 1'b0;
    repeat (12) begin
      check(done == 1'b0, "R6 start in done cycle ignored", int'(done), 0);
      check(int'(product) == 54, "R6 product kept", int'(product), 54);
      @(negedge clk);
    end

    // R7: mcand change after acceptance
    run_op(4'hB, 4'h7, 2, 0, p, l);
    check(p == 77, "R7 mcand captured", p, 77);

    // R8: reset mid-run aborts
    @(negedge clk);
    mcand = 4'hE; mplier = 4'hD; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(product == '0, "R8 product cleared by reset", int'(product), 0);
    repeat (15) begin
      @(negedge clk);
      check(done == 1'b0, "R8 no done after abort", int'(done), 0);
    end
    run_op(4'hC, 4'h5, 0, -1, p, l);
    check(p == 60, "R8 product after abort", p, 60);
    check(l == W + 2, "R8 latency after abort", l, W + 2);

    finish_run();
  end
endmodule